// File: doc/BRIEF.md
# Video Contention Wait Generator

This block drives the active-low WAIT input of an 8-bit CPU that shares a memory bank and one IO port with a video controller. The controller fetches display data in groups of eight CPU cycles and needs the bus for six of them. The block watches the horizontal pixel counter, a fetch-active flag, three address lines and the two request strobes. It holds the CPU off the bus whenever an access would collide with a fetch.

Two timing rules apply. A memory request to the shared bank waits until the first free slot of the group. An IO request whose port address lies in the shared range uses IO timing: it waits only during the first four slots of each group. An access to the controller's own port is stalled only in its second T-state. It is released two cycles early, so its fourth T-state lands in a free slot. After that release, all contention is suppressed until the IO strobe goes high again. The wait output and an optional clock-stretch enable are registered on the falling CPU clock edge.

Top module: `contention_wait`

## Requirements
- R1: An address is contended only when A14=1 and A15=0. A memory request to any other address never drives WAIT low.
- R2: A memory request (mreq_n=0) to a contended address while fetch is active drives wait_n low for slots 0 to 5 of the fetch group. The slot is hcount[SLOT_LSB+2:SLOT_LSB].
- R3: An IO request (iorq_n=0, mreq_n=1) with A0=1 and a contended address waits in slots 0 to 3. The same request to a non-contended address never waits.
- R4: An IO request with A0=0 selects the controller's port. In its first cycle, and in each following cycle while it is still held, the request waits if the slot is 0 to 3. The first cycle in slot 4 to 7 releases it.
- R5: Once the port access has been released, wait_n stays high until iorq_n returns high, even if the address is contended and the slot is busy.
- R6: After iorq_n has been high for one cycle, a new port access is again timed by R4.
- R7: When fetch_active is low, wait_n stays high for every kind of access.
- R8: Slots 6 and 7 never wait. Slots 4 and 5 wait for memory timing but not for IO timing.
- R9: wait_n and stretch_en update on the falling clock edge, one falling edge after the inputs that cause them. A synchronous reset sampled on that edge forces wait_n high and stretch_en low.
- R10: With STRETCH_OUT=1, stretch_en is high exactly when wait_n is low.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | HC_W | Horizontal pixel counter |
| fetch_active | input | 1 | High while the controller fetches display data |
| addr_a0 | input | 1 | CPU address bit 0 |
| addr_a14 | input | 1 | CPU address bit 14 |
| addr_a15 | input | 1 | CPU address bit 15 |
| mreq_n | input | 1 | Active-low memory request strobe |
| iorq_n | input | 1 | Active-low IO request strobe |
| wait_n | output | 1 | Active-low wait to the CPU |
| stretch_en | output | 1 | High while the CPU clock should be stretched |

## Verification
Single-cycle patterns cover memory requests, IO requests with A0 high, and accesses in and out of the shared range. They run with fetch on and off, across busy slots, free slots and slots 4 and 5. These cases separate the two busy windows from the address decode and from the fetch gate. Directed port sequences start a port access in slot 0, slot 2 and slot 5, and hold iorq_n low across a whole group. They show that the stall ends at slot 4 and that suppression lasts until the strobe is released. They also show that a fresh access is timed anew. A reset applied under full contention checks the forced release.

// File: rtl/cvw_pkg.sv
package cvw_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HOLD = 2'd1,
    PS_SUPP = 2'd2
  } port_state_e;
endpackage

// File: rtl/cvw_slot_busy.sv
// Decodes the CPU-cycle slot of the fetch group into the two busy windows.
module cvw_slot_busy #(
  parameter int HC_W     = 9,
  parameter int SLOT_LSB = 1
) (
  input  logic [HC_W-1:0] hcount,
  input  logic            fetch_active,
  output logic            mem_busy,
  output logic            io_busy
);
  localparam int SLOT_MSB = SLOT_LSB + 2;

  logic [2:0] slot;
  assign slot = hcount[SLOT_MSB:SLOT_LSB];

  // memory timing: slots 0..5 busy; IO timing releases two slots early
  assign mem_busy = fetch_active & ~(slot[2] & slot[1]);
  assign io_busy  = fetch_active & ~slot[2];
endmodule

// File: rtl/cvw_port_seq.sv
// Tracks one access to the controller's own port: T2 stall, then suppression.
module cvw_port_seq
  import cvw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_sel,
  input  logic iorq_n,
  input  logic io_busy,
  output logic port_wait,
  output logic suppress
);
  port_state_e state_q, state_d;
  logic in_t2;

  always_comb begin
    in_t2     = (state_q == PS_IDLE && port_sel) ||
                (state_q == PS_HOLD && !iorq_n);
    port_wait = in_t2 & io_busy;
    suppress  = (state_q == PS_SUPP) && !iorq_n;
    state_d   = state_q;
    case (state_q)
      PS_IDLE: if (port_sel) state_d = port_wait ? PS_HOLD : PS_SUPP;
      PS_HOLD: if (iorq_n) state_d = PS_IDLE;
               else state_d = port_wait ? PS_HOLD : PS_SUPP;
      PS_SUPP: if (iorq_n) state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(negedge clk) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/contention_wait.sv
module contention_wait #(
  parameter int HC_W        = 9,
  parameter int SLOT_LSB    = 1,
  parameter bit STRETCH_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HC_W-1:0] hcount,
  input  logic            fetch_active,
  input  logic            addr_a0,
  input  logic            addr_a14,
  input  logic            addr_a15,
  input  logic            mreq_n,
  input  logic            iorq_n,
  output logic            wait_n,
  output logic            stretch_en
);
  logic mem_busy, io_busy;
  logic contended, mem_req, io_req, port_sel;
  logic port_wait, suppress;
  logic wait_d, wait_q;

  cvw_slot_busy #(.HC_W(HC_W), .SLOT_LSB(SLOT_LSB)) u_slot (
    .hcount       (hcount),
    .fetch_active (fetch_active),
    .mem_busy     (mem_busy),
    .io_busy      (io_busy)
  );

  assign contended = addr_a14 & ~addr_a15;
  assign mem_req   = ~mreq_n;
  assign io_req    = ~iorq_n & mreq_n;
  assign port_sel  = io_req & ~addr_a0;

  cvw_port_seq u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .iorq_n    (iorq_n),
    .io_busy   (io_busy),
    .port_wait (port_wait),
    .suppress  (suppress)
  );

  // memory strobe picks memory timing; otherwise IO timing unless suppressed
  assign wait_d = (mem_req & contended & mem_busy) |
                  (io_req & ~suppress & ((contended & io_busy) | port_wait));

  always_ff @(negedge clk) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_d;
  end
  assign wait_n = ~wait_q;

  generate
    if (STRETCH_OUT) begin : g_stretch
      logic stretch_q;
      always_ff @(negedge clk) begin
        if (!rst_n) stretch_q <= 1'b0;
        else        stretch_q <= wait_d;
      end
      assign stretch_en = stretch_q;
    end else begin : g_no_stretch
      assign stretch_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/contention_wait_checker.sv
module contention_wait_checker #(
  parameter int HC_W     = 9,
  parameter int SLOT_LSB = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HC_W-1:0] hcount,
  input logic            fetch_active,
  input logic            addr_a14,
  input logic            addr_a15,
  input logic            mreq_n,
  input logic            iorq_n,
  input logic            wait_n
);
  logic [2:0] slot;
  assign slot = hcount[SLOT_LSB+2:SLOT_LSB];

  p_fetch_off_r7: assert property (@(negedge clk) disable iff (!rst_n)
    !fetch_active |=> wait_n);

  p_mem_busy_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (!mreq_n && addr_a14 && !addr_a15 && fetch_active && slot < 3'd6) |=> !wait_n);

  p_outside_r1: assert property (@(negedge clk) disable iff (!rst_n)
    (!mreq_n && !(addr_a14 && !addr_a15)) |=> wait_n);

  p_free_slot_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (slot[2] && slot[1]) |=> wait_n);

  p_io_slot45_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (mreq_n && slot[2]) |=> wait_n);
endmodule

bind contention_wait contention_wait_checker #(.HC_W(HC_W), .SLOT_LSB(SLOT_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcount(hcount), .fetch_active(fetch_active),
  .addr_a14(addr_a14), .addr_a15(addr_a15), .mreq_n(mreq_n),
  .iorq_n(iorq_n), .wait_n(wait_n)
);

// File: tb/contention_wait_bench.sv
`timescale 1ns/1ps
module contention_wait_bench;
  localparam int HC_W = 9;
  localparam int SLOT_LSB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HC_W-1:0] hcount = '0;
  logic fetch_active = 1'b0;
  logic addr_a0 = 1'b1, addr_a14 = 1'b0, addr_a15 = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1;
  logic wait_n, stretch_en;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  contention_wait #(.HC_W(HC_W), .SLOT_LSB(SLOT_LSB), .STRETCH_OUT(1'b1)) u_contention_wait (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .fetch_active(fetch_active),
    .addr_a0(addr_a0), .addr_a14(addr_a14), .addr_a15(addr_a15),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .wait_n(wait_n), .stretch_en(stretch_en)
  );

  // {slot[2:0], fetch, a0, a14, a15, mreq_n, iorq_n, exp_wait_n, req_id[3:0]}
  localparam logic [13:0] VECS [12] = '{
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 slot0 mem
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 slot5 mem
    {3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 free slot
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 free slot
    {3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1},  // R1 upper bank
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},  // R1 lower bank
    {3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 fetch off
    {3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 io contended
    {3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 io slot4
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 io outside
    {3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 io fetch off
    {3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8}   // R8 mem slot4
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // inputs set mid-cycle; one falling edge later the output is sampled
  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic set_slot(input int s);
    hcount = HC_W'(s << SLOT_LSB);
  endtask

  task automatic idle();
    mreq_n = 1'b1; iorq_n = 1'b1; addr_a0 = 1'b1;
    step();
  endtask

  task automatic port_cycle(input int s, input logic exp, input string req);
    set_slot(s); addr_a0 = 1'b0; mreq_n = 1'b1; iorq_n = 1'b0;
    step();
    check(req, wait_n, exp);
    check("R10", stretch_en, ~exp);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset under full contention
    fetch_active = 1'b1; addr_a14 = 1'b1; mreq_n = 1'b0; set_slot(0);
    step(); step();
    check("R9 reset wait", wait_n, 1'b1);
    check("R9 reset stretch", stretch_en, 1'b0);
    rst_n = 1'b1;
    step();
    check("R9 after reset", wait_n, 1'b0);
    rst_n = 1'b0;
    step();
    check("R9 sync reset", wait_n, 1'b1);
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < 12; i++) begin
      logic [13:0] v;
      v = VECS[i];
      set_slot(int'(v[13:11]));
      fetch_active = v[10]; addr_a0 = v[9]; addr_a14 = v[8]; addr_a15 = v[7];
      mreq_n = v[6]; iorq_n = v[5];
      step();
      check($sformatf("R%0d vec%0d", v[3:0], i), wait_n, v[4]);
      check("R10", stretch_en, ~v[4]);
      idle();
    end

    // R4/R5: port access starting at slot 0, contended address held
    fetch_active = 1'b1; addr_a14 = 1'b1; addr_a15 = 1'b0;
    port_cycle(0, 1'b0, "R4 t2 slot0");
    port_cycle(1, 1'b0, "R4 hold slot1");
    port_cycle(2, 1'b0, "R4 hold slot2");
    port_cycle(3, 1'b0, "R4 hold slot3");
    port_cycle(4, 1'b1, "R4 release slot4");
    port_cycle(5, 1'b1, "R5 slot5");
    port_cycle(6, 1'b1, "R5 slot6");
    port_cycle(7, 1'b1, "R5 slot7");
    port_cycle(0, 1'b1, "R5 suppressed slot0");
    port_cycle(1, 1'b1, "R5 suppressed slot1");
    idle();
    check("R6 strobe high", wait_n, 1'b1);

    // R6: fresh access at slot 2 is timed anew
    port_cycle(2, 1'b0, "R6 t2 slot2");
    port_cycle(3, 1'b0, "R6 hold slot3");
    port_cycle(4, 1'b1, "R6 release slot4");
    port_cycle(0, 1'b1, "R5 after release");
    idle();

    // R4: access starting in slot 5 is never stalled
    addr_a14 = 1'b0;
    port_cycle(5, 1'b1, "R4 start slot5");
    port_cycle(0, 1'b1, "R5 no stall later");
    idle();

    // R7: port access with fetch off
    fetch_active = 1'b0;
    port_cycle(1, 1'b1, "R7 port fetch off");
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule